// File: doc/BRIEF.md
# Clock Alarm Transition Latch

This block sits beside a clock synchroniser and watches four alarm levels it produces: primary reference lost, secondary reference lost, PLL holdover and PLL unlocked. Each level is brought into the local clock domain and compared with its value one cycle earlier. Every transition is recorded in its own sticky bit of an 8-bit cause register, with separate bits for each direction of each alarm. An interrupt line stays high while any cause bit is set.

A host reads the block through a byte-wide read port with a 2-bit register select. It can read the live alarm levels, the cause register, a configuration byte that gives the assigned interrupt number, and a reference byte that reports which reference the synchroniser is using. Reading the cause register returns the events gathered so far and clears them all at once in the same access. A host therefore flushes stale events by reading the cause register once before it enables the interrupt. An event that lands in the same cycle as that read is kept for the next read.

The interrupt is driven by a two-state machine. In `ST_QUIET` no event is pending and `irq` is low. When any transition is detected it moves to `ST_PENDING` (transition "event"), and `irq` is high. It returns to `ST_QUIET` on a cause read in a cycle with no new transition (transition "drain"). A cause read that coincides with a new transition leaves it in `ST_PENDING`.

Top module: `alm_event_latch`

## Requirements
- R1: A 0→1 transition of alarm i sets cause bit 2i. Alarm index 0 is primary lost, 1 is secondary lost, 2 is holdover, 3 is unlocked, so bit 0 is primary lost rising, bit 2 is secondary lost rising, bit 4 is holdover entry and bit 6 is unlock rising.
- R2: A 1→0 transition of alarm i sets cause bit 2i+1 (bit 1 primary lost falling, bit 3 secondary lost falling, bit 5 holdover exit, bit 7 unlock falling).
- R3: Cause bits accumulate until the cause register is read at select 2. That read returns every accumulated bit and clears all of them in the same clock edge.
- R4: A transition detected in the same cycle as a cause read is not lost. After that read, the cause register holds exactly that cycle's transitions.
- R5: `irq` is high exactly when any cause bit is set. It falls in the cycle after a clearing read if no new transition arrived in that cycle.
- R6: Reading select 1 gives the synchronised alarm levels in the upper nibble: bit 7 primary lost, bit 6 secondary lost, bit 5 holdover, bit 4 unlocked. The lower nibble reads zero.
- R7: Reading select 0 gives the parameter `IRQ_ID` in bits 3:0 and zero above. The value 0xF means that no interrupt is assigned.
- R8: Reading select 3 gives the synchronised reference-in-use input in bit 3 and zero in every other bit.
- R9: After reset all cause bits are zero and `irq` is low, even when alarm inputs are held active through reset.
- R10: An alarm input change is recorded in the cause register on the third rising clock edge after it is applied. It passes through two synchroniser flops and is then detected.
- R11: A read at selects 0, 1 or 3, and any cycle without a read, leaves the cause bits unchanged except for new transitions being added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alarm_in | input | 4 | Asynchronous alarm levels: [0] primary lost, [1] secondary lost, [2] holdover, [3] unlocked |
| ref_in_use | input | 1 | Asynchronous level: reference currently selected by the synchroniser |
| rd_en | input | 1 | Read strobe; a read at select 2 clears the cause register |
| rd_addr | input | 2 | Register select: 0 config, 1 alarm levels, 2 cause, 3 reference |
| rd_data | output | 8 | Combinational read data for the selected register |
| irq | output | 1 | Level interrupt, high while any cause bit is set |

## Verification
A wrong history value or a mis-wired edge detector shows up as a wrong or extra cause bit. It appears at the cause read three edges after the offending input change, and `irq` rises in the same cycle. If the clear logic drops a coincident transition, the next cause read comes back zero and `irq` falls one cycle after the read. A wrong state in the interrupt machine makes `irq` disagree with a cause read taken in the same cycle.

// File: rtl/alm_pkg.sv
`timescale 1ns/1ps
package alm_pkg;
    localparam int N_ALARM = 4;
    localparam int CAUSE_W = 2 * N_ALARM;
    localparam int DATA_W  = CAUSE_W;
    localparam int SEL_W   = 2;
    localparam int REF_BIT = 3;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [SEL_W-1:0] {
        REG_CFG   = 2'd0,
        REG_STAT  = 2'd1,
        REG_CAUSE = 2'd2,
        REG_REF   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_QUIET   = 1'b0,
        ST_PENDING = 1'b1
    } irq_state_e;
endpackage

// File: rtl/alm_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchroniser; reset preloads every stage with the input
module alm_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= din;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/alm_cause.sv
`timescale 1ns/1ps
// Transition detector, sticky cause register and interrupt state machine
module alm_cause
    import alm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_ALARM-1:0] lvl,
    input  logic               clr,
    output logic [CAUSE_W-1:0] edges,
    output logic [CAUSE_W-1:0] cause,
    output logic               irq
);
    logic [N_ALARM-1:0] lvl_d;
    irq_state_e         state_q, state_d;

    // history: loaded with the level during reset so held alarms raise nothing
    always_ff @(posedge clk) begin
        lvl_d <= lvl;
    end

    for (genvar i = 0; i < N_ALARM; i++) begin : g_edge
        assign edges[2*i]   =  lvl[i] & ~lvl_d[i];
        assign edges[2*i+1] = ~lvl[i] &  lvl_d[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   cause <= '0;
        else if (clr) cause <= edges;
        else          cause <= cause | edges;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // transitions: event (QUIET->PENDING), drain (PENDING->QUIET)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:   if (|edges) state_d = ST_PENDING;
            ST_PENDING: if (clr && !(|edges)) state_d = ST_QUIET;
            default:    state_d = ST_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        irq = (state_q == ST_PENDING);
    end
endmodule

// File: rtl/alm_event_latch.sv
`timescale 1ns/1ps
module alm_event_latch
    import alm_pkg::*;
#(
    parameter logic [3:0] IRQ_ID = 4'd5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_ALARM-1:0] alarm_in,
    input  logic               ref_in_use,
    input  logic               rd_en,
    input  logic [SEL_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq
);
    logic [N_ALARM-1:0] lvl_s;
    logic               ref_s;
    logic [CAUSE_W-1:0] edges_w;
    logic [CAUSE_W-1:0] cause_q;
    logic               clr_w;
    reg_sel_e           sel;

    alm_sync #(.W(N_ALARM), .STAGES(SYNC_STAGES)) u_sync_alm (
        .clk (clk),
        .rst_n (rst_n),
        .din (alarm_in),
        .q   (lvl_s)
    );

    alm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_ref (
        .clk (clk),
        .rst_n (rst_n),
        .din (ref_in_use),
        .q   (ref_s)
    );

    assign sel   = reg_sel_e'(rd_addr);
    assign clr_w = rd_en && (sel == REG_CAUSE);

    alm_cause u_cause (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl_s),
        .clr   (clr_w),
        .edges (edges_w),
        .cause (cause_q),
        .irq   (irq)
    );

    always_comb begin
        rd_data = '0;
        unique case (sel)
            REG_CFG:   rd_data[3:0] = IRQ_ID;
            REG_STAT:  for (int i = 0; i < N_ALARM; i++) rd_data[DATA_W-1-i] = lvl_s[i];
            REG_CAUSE: rd_data = cause_q;
            REG_REF:   rd_data[REF_BIT] = ref_s;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/alm_event_latch_chk.sv
`timescale 1ns/1ps
module alm_event_latch_chk
    import alm_pkg::*;
#(
    parameter logic [3:0] IRQ_ID = 4'd5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_ALARM-1:0] lvl,
    input logic [CAUSE_W-1:0] edges,
    input logic [CAUSE_W-1:0] cause,
    input logic               irq,
    input logic               rd_en,
    input logic [SEL_W-1:0]   rd_addr,
    input logic [DATA_W-1:0]  rd_data
);
    for (genvar i = 0; i < N_ALARM; i++) begin : g_dir
        p_rise_sets_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lvl[i]) |=> cause[2*i]);
        p_fall_sets_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lvl[i]) |=> cause[2*i+1]);
    end

    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == REG_CAUSE && edges == '0) |=> cause == '0);

    p_coincident_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == REG_CAUSE) |=> cause == $past(edges));

    p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (cause != '0));

    p_status_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == REG_STAT) |-> rd_data[3:0] == 4'h0);

    p_config_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == REG_CFG) |-> rd_data == {4'h0, IRQ_ID});

    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_addr == REG_CAUSE) |=> ($past(cause) & ~cause) == '0);
endmodule

bind alm_event_latch alm_event_latch_chk #(.IRQ_ID(IRQ_ID)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (lvl_s),
    .edges   (edges_w),
    .cause   (cause_q),
    .irq     (irq),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/sim_alm_event_latch.sv
`timescale 1ns/1ps
module sim_alm_event_latch;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] alarm_in;
    logic       ref_in_use;
    logic       rd_en;
    logic [1:0] rd_addr;
    logic [7:0] rd_data;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    // bench model: two-edge synchroniser delay (R10), history, cause
    logic [3:0] m_s1, m_s2, m_h;
    logic [7:0] m_cause;
    logic       m_r1, m_r2;

    always #2.5 clk = ~clk;

    alm_event_latch #(.IRQ_ID(4'd5)) u0 (
        .clk (clk), .rst_n (rst_n), .alarm_in (alarm_in), .ref_in_use (ref_in_use),
        .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data), .irq (irq)
    );

    function automatic logic [7:0] edge_bits(logic [3:0] prev, logic [3:0] cur);
        logic [7:0] e = '0;
        for (int i = 0; i < 4; i++) begin
            e[2*i]   = cur[i] & ~prev[i];
            e[2*i+1] = ~cur[i] & prev[i];
        end
        return e;
    endfunction

    function automatic logic [7:0] stat_of(logic [3:0] l);
        return {l[0], l[1], l[2], l[3], 4'h0};
    endfunction

    function automatic logic [7:0] exp_read(logic [1:0] a);
        case (a)
            2'd0:    return 8'h05;
            2'd1:    return stat_of(m_s2);
            2'd2:    return m_cause;
            default: return {4'h0, m_r2, 3'b000};
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        logic [7:0] e;
        @(posedge clk);
        cycles++;
        if (!rst_n) begin
            m_s1 = alarm_in; m_s2 = alarm_in; m_h = alarm_in;
            m_cause = '0; m_r1 = ref_in_use; m_r2 = ref_in_use;
        end else begin
            e = edge_bits(m_h, m_s2);
            if (rd_en && rd_addr == 2'd2) m_cause = e;
            else                          m_cause = m_cause | e;
            m_h = m_s2; m_s2 = m_s1; m_s1 = alarm_in;
            m_r2 = m_r1; m_r1 = ref_in_use;
        end
        #1;
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string req);
        rd_addr = a;
        rd_en   = 1'b1;
        #1;
        check(req, rd_data, exp);
        tick();
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        wait (cycles > 50000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
        finish_run();
    end

    initial begin
        void'($urandom(32'h0000_2b9d));
        rst_n = 1'b0; alarm_in = 4'b0101; ref_in_use = 1'b0;
        rd_en = 1'b0; rd_addr = 2'd0;
        repeat (4) tick();
        rst_n = 1'b1;
        tick();

        // R9: alarms held through reset raise nothing
        check("R9 irq after reset", {7'd0, irq}, 8'h00);
        rd(2'd2, 8'h00, "R9 cause after reset");
        // R6 levels, R7 config
        rd(2'd1, 8'hA0, "R6 status 0101");
        rd(2'd0, 8'h05, "R7 config");
        // R8 reference bit 3
        ref_in_use = 1'b1;
        repeat (3) tick();
        rd(2'd3, 8'h08, "R8 reference");

        // R10 latency, R1 secondary rising -> bit 2
        alarm_in = 4'b0111;
        tick(); tick();
        check("R10 not yet", {7'd0, irq}, 8'h00);
        tick();
        check("R10 third edge", {7'd0, irq}, 8'h01);
        rd(2'd2, 8'h04, "R1 secondary rise");
        check("R5 irq falls after read", {7'd0, irq}, 8'h00);

        // R2 primary falling -> bit 1; R11 status read does not clear
        alarm_in = 4'b0110;
        repeat (3) tick();
        rd(2'd1, 8'h60, "R6 status 0110");
        rd(2'd0, 8'h05, "R11 config read");
        rd(2'd2, 8'h02, "R2 primary fall");

        // R3 accumulation: unlock rise (bit6) then holdover exit (bit5)
        alarm_in = 4'b1110;
        tick();
        alarm_in = 4'b1010;
        repeat (4) tick();
        check("R5 irq pending", {7'd0, irq}, 8'h01);
        rd(2'd2, 8'h60, "R3 accumulated");
        rd(2'd2, 8'h00, "R3 cleared");

        // R4: holdover entry pending, unlock fall lands on the clearing edge
        alarm_in = 4'b1110;
        repeat (3) tick();
        alarm_in = 4'b0110;
        tick(); tick();
        rd(2'd2, 8'h10, "R4 before coincident");
        check("R4 irq stays", {7'd0, irq}, 8'h01);
        rd(2'd2, 8'h80, "R4 coincident kept");

        // constrained random
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(7) == 0) alarm_in[$urandom_range(3)] ^= 1'b1;
            if ($urandom_range(15) == 0) ref_in_use = ~ref_in_use;
            rd_en   = ($urandom_range(3) == 0);
            rd_addr = 2'($urandom_range(3));
            #1;
            check("R5 irq random", {7'd0, irq}, {7'd0, (m_cause != 8'h00)});
            if (rd_en) check("R11 random read", rd_data, exp_read(rd_addr));
            tick();
        end
        rd_en = 1'b0;
        finish_run();
    end
endmodule